// File: doc/BRIEF.md
# Dual-Port Channel Mailbox with Event Flags

This block is the coprocessor side of a shared-memory message exchange between a host and a coprocessor. It holds seven outbound ("send") channels and seven inbound ("receive") channels. Each channel is a queue of depth one: a 32-byte message buffer plus a small state register. The state walks a four-step handshake: idle (0), new (1), received (2), complete (3).

On a send channel the host fills the buffer and marks it new. The coprocessor moves it to received and then to complete, leaving any reply in that same send buffer. The host then writes it back to idle. A receive channel runs the mirror image. The coprocessor posts a message as new, and the host moves it through received to complete, leaving its reply in the receive buffer. The coprocessor then returns it to idle.

Two sticky event flags tell the host what happened. `int0` marks a send channel reaching complete. `int1` marks a receive channel reaching new. Both drive one interrupt line. The host reads the two flags to tell the events apart, and clears each flag with its own pulse.

Both sides reach the same byte-wide address space through identical request ports with valid/ready handshakes. Rules for back-pressure: a requester raises `*_valid` and holds `*_we`, `*_addr` and `*_wdata` stable until it sees `*_ready` high at a rising edge. `*_ready` is high only in a cycle where that port is granted, and it may stay low while the other port is being served. A read is answered exactly one cycle after acceptance, with a single-cycle `*_rvalid` pulse. That response cannot be stalled.

Top module: `mbox_hub`

## Requirements
- R1: A send buffer byte sits at address ch*32+b, and a receive buffer byte sits at 256+ch*32+b (ch 0..6, b 0..31). Each byte written through the host port reads back unchanged, and channels do not alias one another.
- R2: Both ports address the same storage. A byte written through the coprocessor port (for example a reply placed in a send buffer) reads back through the host port, and the reverse also holds.
- R3: Send channel states sit at 480+ch and receive channel states at 488+ch. Only the low two bits of a state write are kept. A state read returns those two bits with bits 7:2 zero.
- R4: `int0` becomes 1 in the cycle after a write of value 3 to a send state that did not already hold 3. A write of 0, 1 or 2, or a write of 3 to a state already at 3, does not set it.
- R5: `int1` becomes 1 in the cycle after a write of value 1 to a receive state that did not already hold 1. Other receive-state values do not set it.
- R6: Each flag holds until its own clear input is seen high at a clock edge. A clear of one flag leaves the other unchanged. A set event in the same cycle as a clear wins.
- R7: `host_irq` is high exactly when `int0` or `int1` is high.
- R8: At most one access is granted per cycle. When both ports request in the same cycle, the grant alternates between them from one contended cycle to the next, and the host wins the first contended cycle after reset.
- R9: A read accepted at edge k shows its data with a one-cycle `*_rvalid` pulse after edge k, on the requesting port only.
- R10: Addresses outside the mapped ranges read as zero. Writes to them change no buffer, no state and no flag.
- R11: After reset all fourteen states read 0, both flags and `host_irq` are 0, and neither `*_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Host request accepted this cycle |
| h_we | input | 1 | Host request is a write |
| h_addr | input | 9 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 8 | Host read data |
| c_valid | input | 1 | Coprocessor access request |
| c_ready | output | 1 | Coprocessor request accepted this cycle |
| c_we | input | 1 | Coprocessor request is a write |
| c_addr | input | 9 | Coprocessor byte address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rvalid | output | 1 | Coprocessor read data valid |
| c_rdata | output | 8 | Coprocessor read data |
| clr_int0 | input | 1 | Host clear of the send-complete flag |
| clr_int1 | input | 1 | Host clear of the receive-new flag |
| int0 | output | 1 | Send-complete flag |
| int1 | output | 1 | Receive-new flag |
| host_irq | output | 1 | Combined host interrupt |

## Verification
A wrong state register shows up in two ways. The next state read returns the wrong two-bit value, and a later write of complete or new either raises a flag that should stay low or fails to raise one; both are visible one cycle after the write edge. A buffer decode fault makes a channel read back another channel's byte, so the bench writes distinct patterns at channel and byte extremes through both ports. A wrong arbitration turn or response routing appears in the same cycle as a missing `*_ready`, or one cycle later as an `*_rvalid` on the wrong port.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEW  = 2'd1,
    ST_RCVD = 2'd2,
    ST_DONE = 2'd3
  } chan_state_e;
endpackage

// File: rtl/mbox_arb.sv
`timescale 1ns/1ps
module mbox_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic h_valid,
  input  logic c_valid,
  output logic h_gnt,
  output logic c_gnt
);
  logic turn_c;  // 1: coprocessor wins next contended cycle

  always_comb begin
    h_gnt = h_valid && (!c_valid || !turn_c);
    c_gnt = c_valid && (!h_valid || turn_c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  turn_c <= 1'b0;
    else if (h_valid && c_valid) turn_c <= ~turn_c;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h_gnt, c_gnt}));  // R8
  AST_GNT_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && c_valid && h_gnt) |=> !(h_valid && c_valid && h_gnt));  // R8
endmodule

// File: rtl/mbox_store.sv
`timescale 1ns/1ps
module mbox_store import mbox_pkg::*; #(
  parameter int NCH       = 7,
  parameter int MSG_BYTES = 32,
  parameter int AW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_src,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [7:0]    acc_wdata,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          rd_src,
  output logic          send_done_evt,
  output logic          recv_new_evt
);
  localparam int BUF_BYTES = NCH * MSG_BYTES;
  localparam int RBUF_BASE = 1 << (AW - 1);
  localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SST_BASE  = RBUF_BASE + BUF_BYTES;
  localparam int RST_BASE  = SST_BASE + (1 << CHW);
  localparam int MEM_DEPTH = 2 * BUF_BYTES;
  localparam int MIW       = $clog2(MEM_DEPTH);

  logic [7:0]  mem [MEM_DEPTH];
  chan_state_e send_st [NCH];
  chan_state_e recv_st [NCH];

  int           a;
  logic         hit_sbuf, hit_rbuf, hit_sst, hit_rst;
  logic [MIW-1:0] mem_idx;
  logic [CHW-1:0] st_ch;
  logic         wr_en, rd_en;
  chan_state_e  cur_send, cur_recv, new_val;
  logic [7:0]   rd_sel;

  always_comb begin
    a        = int'(acc_addr);
    hit_sbuf = (a < BUF_BYTES);
    hit_rbuf = (a >= RBUF_BASE) && (a < RBUF_BASE + BUF_BYTES);
    hit_sst  = (a >= SST_BASE) && (a < SST_BASE + NCH);
    hit_rst  = (a >= RST_BASE) && (a < RST_BASE + NCH);
    mem_idx  = hit_sbuf ? MIW'(a) : MIW'(a - RBUF_BASE + BUF_BYTES);
    st_ch    = hit_sst ? CHW'(a - SST_BASE) : CHW'(a - RST_BASE);
    wr_en    = acc_en && acc_we;
    rd_en    = acc_en && !acc_we;
    new_val  = chan_state_e'(acc_wdata[1:0]);
    cur_send = hit_sst ? send_st[st_ch] : ST_IDLE;
    cur_recv = hit_rst ? recv_st[st_ch] : ST_IDLE;
  end

  // Transition events: the written value differs from the stored one
  always_comb begin
    send_done_evt = wr_en && hit_sst && (new_val == ST_DONE) && (cur_send != ST_DONE);
    recv_new_evt  = wr_en && hit_rst && (new_val == ST_NEW)  && (cur_recv != ST_NEW);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        send_st[g] <= ST_IDLE;
      else if (wr_en && hit_sst && (st_ch == CHW'(g)))
        send_st[g] <= new_val;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        recv_st[g] <= ST_IDLE;
      else if (wr_en && hit_rst && (st_ch == CHW'(g)))
        recv_st[g] <= new_val;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && (hit_sbuf || hit_rbuf))
      mem[mem_idx] <= acc_wdata;
  end

  always_comb begin
    if (hit_sbuf || hit_rbuf) rd_sel = mem[mem_idx];
    else if (hit_sst)         rd_sel = {6'd0, cur_send};
    else if (hit_rst)         rd_sel = {6'd0, cur_recv};
    else                      rd_sel = 8'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'd0;
      rd_src   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= rd_sel;
        rd_src  <= acc_src;
      end
    end
  end

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_done_evt, recv_new_evt}));  // R4
endmodule

// File: rtl/mbox_irq.sv
`timescale 1ns/1ps
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set0,
  input  logic set1,
  input  logic clr0,
  input  logic clr1,
  output logic int0,
  output logic int1,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int0 <= 1'b0;
      int1 <= 1'b0;
    end else begin
      if (set0)      int0 <= 1'b1;
      else if (clr0) int0 <= 1'b0;
      if (set1)      int1 <= 1'b1;
      else if (clr1) int1 <= 1'b0;
    end
  end

  assign irq = int0 | int1;

  AST_INT0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set0 |=> int0);  // R4
  AST_INT1_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set1 |=> int1);  // R5
  AST_INT0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int0 && !clr0) |=> int0);  // R6
  AST_INT0_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !set0) |=> !int0);  // R6
  AST_INT1_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && !set1) |=> !int1);  // R6
endmodule

// File: rtl/mbox_hub.sv
`timescale 1ns/1ps
module mbox_hub #(
  parameter int NCH       = 7,
  parameter int MSG_BYTES = 32,
  parameter int AW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  output logic          h_ready,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic          h_rvalid,
  output logic [7:0]    h_rdata,
  input  logic          c_valid,
  output logic          c_ready,
  input  logic          c_we,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_wdata,
  output logic          c_rvalid,
  output logic [7:0]    c_rdata,
  input  logic          clr_int0,
  input  logic          clr_int1,
  output logic          int0,
  output logic          int1,
  output logic          host_irq
);
  logic          h_gnt, c_gnt;
  logic          acc_en, acc_we;
  logic [AW-1:0] acc_addr;
  logic [7:0]    acc_wdata;
  logic [7:0]    rd_data;
  logic          rd_valid, rd_src;
  logic          send_done_evt, recv_new_evt;

  mbox_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .h_valid(h_valid), .c_valid(c_valid),
    .h_gnt(h_gnt), .c_gnt(c_gnt)
  );

  always_comb begin
    acc_en    = h_gnt | c_gnt;
    acc_we    = c_gnt ? c_we    : h_we;
    acc_addr  = c_gnt ? c_addr  : h_addr;
    acc_wdata = c_gnt ? c_wdata : h_wdata;
  end

  mbox_store #(.NCH(NCH), .MSG_BYTES(MSG_BYTES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_src(c_gnt), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_src(rd_src),
    .send_done_evt(send_done_evt), .recv_new_evt(recv_new_evt)
  );

  mbox_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set0(send_done_evt), .set1(recv_new_evt),
    .clr0(clr_int0), .clr1(clr_int1),
    .int0(int0), .int1(int1), .irq(host_irq)
  );

  always_comb begin
    h_ready  = h_gnt;
    c_ready  = c_gnt;
    h_rvalid = rd_valid && !rd_src;
    c_rvalid = rd_valid &&  rd_src;
    h_rdata  = rd_data;
    c_rdata  = rd_data;
  end

  AST_H_RSP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> $past(h_valid && h_ready && !h_we));  // R9
  AST_C_RSP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    c_rvalid |-> $past(c_valid && c_ready && !c_we));  // R9
  AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_rvalid && c_rvalid));  // R9
endmodule

// File: tb/test_mbox_hub.sv
`timescale 1ns/1ps
module test_mbox_hub;
  logic clk = 1'b0;
  logic rst_n;
  logic h_valid, h_we, c_valid, c_we, clr_int0, clr_int1;
  logic [8:0] h_addr, c_addr;
  logic [7:0] h_wdata, c_wdata, h_rdata, c_rdata;
  logic h_ready, c_ready, h_rvalid, c_rvalid, int0, int1, host_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mbox_hub i_mbox_hub (
    .clk(clk), .rst_n(rst_n),
    .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .c_valid(c_valid), .c_ready(c_ready), .c_we(c_we), .c_addr(c_addr),
    .c_wdata(c_wdata), .c_rvalid(c_rvalid), .c_rdata(c_rdata),
    .clr_int0(clr_int0), .clr_int1(clr_int1),
    .int0(int0), .int1(int1), .host_irq(host_irq)
  );

  function automatic int sbuf(int ch, int b); return ch * 32 + b; endfunction
  function automatic int rbuf(int ch, int b); return 256 + ch * 32 + b; endfunction
  function automatic int sst(int ch); return 480 + ch; endfunction
  function automatic int rst_a(int ch); return 488 + ch; endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit cop, input bit we, input int addr, input int wd,
                     output logic [7:0] rd, output logic rv, output logic other_rv);
    @(negedge clk);
    if (cop) begin c_valid = 1; c_we = we; c_addr = 9'(addr); c_wdata = 8'(wd); end
    else     begin h_valid = 1; h_we = we; h_addr = 9'(addr); h_wdata = 8'(wd); end
    #1;
    while (!(cop ? c_ready : h_ready)) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    rd       = cop ? c_rdata  : h_rdata;
    rv       = cop ? c_rvalid : h_rvalid;
    other_rv = cop ? h_rvalid : c_rvalid;
    if (cop) c_valid = 0; else h_valid = 0;
  endtask

  task automatic wr(input bit cop, input int addr, input int wd);
    logic [7:0] d; logic v, ov;
    acc(cop, 1'b1, addr, wd, d, v, ov);
  endtask

  task automatic rd_chk(input bit cop, input int addr, input int exp, input string req);
    logic [7:0] d; logic v, ov;
    acc(cop, 1'b0, addr, 0, d, v, ov);
    chk(req, int'(v), 1);
    chk(req, int'(d), exp);
  endtask

  task automatic pulse_clr(input bit c0, input bit c1);
    @(negedge clk); clr_int0 = c0; clr_int1 = c1;
    @(negedge clk); clr_int0 = 0;  clr_int1 = 0;
  endtask

  task automatic t_reset;
    chk("R11 int0", int'(int0), 0);
    chk("R11 int1", int'(int1), 0);
    chk("R11 irq", int'(host_irq), 0);
    chk("R11 rvalid", int'(h_rvalid | c_rvalid), 0);
    for (int i = 0; i < 7; i++) begin
      rd_chk(0, sst(i), 0, "R11 send state");
      rd_chk(0, rst_a(i), 0, "R11 recv state");
    end
  endtask

  task automatic t_buffers;
    wr(0, sbuf(0, 0), 8'h11);
    wr(0, sbuf(6, 31), 8'h6F);
    wr(0, sbuf(3, 5), 8'h35);
    wr(0, rbuf(0, 0), 8'h90);
    wr(0, rbuf(6, 31), 8'h9F);
    rd_chk(0, sbuf(0, 0), 8'h11, "R1 send ch0");
    rd_chk(0, sbuf(6, 31), 8'h6F, "R1 send ch6 last");
    rd_chk(0, sbuf(3, 5), 8'h35, "R1 send ch3");
    rd_chk(0, rbuf(0, 0), 8'h90, "R1 recv ch0 no alias");
    rd_chk(0, rbuf(6, 31), 8'h9F, "R1 recv ch6 last");
    rd_chk(1, sbuf(3, 5), 8'h35, "R2 cop sees host byte");
  endtask

  task automatic t_reply;
    wr(1, sbuf(2, 0), 8'hE2);
    wr(1, sbuf(2, 31), 8'hE3);
    rd_chk(0, sbuf(2, 0), 8'hE2, "R2 reply in send buf");
    rd_chk(0, sbuf(2, 31), 8'hE3, "R2 reply last byte");
    wr(1, rbuf(4, 7), 8'h47);
    wr(0, rbuf(4, 7), 8'hB7);
    rd_chk(1, rbuf(4, 7), 8'hB7, "R2 host reply in recv buf");
  endtask

  task automatic t_state_bits;
    wr(0, rst_a(4), 8'hFE);
    rd_chk(0, rst_a(4), 2, "R3 low bits kept");
    chk("R5 value 2 no set", int'(int1), 0);
    wr(1, sst(6), 8'hA9);
    rd_chk(1, sst(6), 1, "R3 send state bits");
    chk("R4 value 1 no set", int'(int0), 0);
    wr(0, sst(6), 0);
  endtask

  task automatic t_int0;
    wr(1, sst(5), 1);
    wr(1, sst(5), 2);
    chk("R4 no set before complete", int'(int0), 0);
    wr(1, sst(5), 3);
    chk("R4 int0 set", int'(int0), 1);
    chk("R7 irq from int0", int'(host_irq), 1);
    chk("R4 int1 untouched", int'(int1), 0);
    pulse_clr(0, 1);
    chk("R6 clr1 leaves int0", int'(int0), 1);
    pulse_clr(1, 0);
    chk("R6 int0 cleared", int'(int0), 0);
    chk("R7 irq low", int'(host_irq), 0);
    wr(1, sst(5), 3);
    chk("R4 rewrite complete no set", int'(int0), 0);
    wr(0, sst(5), 0);
    rd_chk(0, sst(5), 0, "R3 host returns idle");
    chk("R4 idle write no set", int'(int0), 0);
  endtask

  task automatic t_int1;
    wr(1, rst_a(0), 1);
    chk("R5 int1 set", int'(int1), 1);
    chk("R7 irq from int1", int'(host_irq), 1);
    chk("R5 int0 untouched", int'(int0), 0);
    repeat (5) @(negedge clk);
    chk("R6 int1 held", int'(int1), 1);
    wr(0, rst_a(0), 2);
    wr(0, rst_a(0), 3);
    chk("R6 int1 still held", int'(int1), 1);
    pulse_clr(0, 1);
    chk("R6 int1 cleared", int'(int1), 0);
    wr(1, rst_a(0), 0);
    chk("R5 idle no set", int'(int1), 0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    h_valid = 1; h_we = 1; h_addr = 9'(sst(1)); h_wdata = 8'd3; clr_int0 = 1;
    @(negedge clk);
    h_valid = 0; clr_int0 = 0;
    chk("R6 set wins over clear", int'(int0), 1);
    pulse_clr(1, 0);
    chk("R6 cleared after", int'(int0), 0);
    wr(0, sst(1), 0);
  endtask

  task automatic t_arb;
    @(negedge clk);
    h_valid = 1; h_we = 1; h_addr = 9'(sbuf(1, 0)); h_wdata = 8'hA1;
    c_valid = 1; c_we = 1; c_addr = 9'(rbuf(1, 0)); c_wdata = 8'hC1;
    #1;
    chk("R8 host first contention", int'(h_ready), 1);
    chk("R8 cop waits", int'(c_ready), 0);
    @(negedge clk); h_valid = 0; #1;
    chk("R8 cop served next", int'(c_ready), 1);
    @(negedge clk); c_valid = 0;
    @(negedge clk);
    h_valid = 1; h_addr = 9'(sbuf(1, 1)); h_wdata = 8'hA2;
    c_valid = 1; c_addr = 9'(rbuf(1, 1)); c_wdata = 8'hC2;
    #1;
    chk("R8 cop second contention", int'(c_ready), 1);
    chk("R8 host waits", int'(h_ready), 0);
    @(negedge clk); c_valid = 0; #1;
    chk("R8 host served next", int'(h_ready), 1);
    @(negedge clk); h_valid = 0;
    rd_chk(0, sbuf(1, 0), 8'hA1, "R8 host write landed");
    rd_chk(0, rbuf(1, 0), 8'hC1, "R8 cop write landed");
    rd_chk(1, sbuf(1, 1), 8'hA2, "R8 host write 2 landed");
    rd_chk(1, rbuf(1, 1), 8'hC2, "R8 cop write 2 landed");
  endtask

  task automatic t_read_lat;
    logic [7:0] d; logic v, ov;
    acc(1, 1'b0, sbuf(6, 31), 0, d, v, ov);
    chk("R9 cop rvalid", int'(v), 1);
    chk("R9 host no rvalid", int'(ov), 0);
    chk("R9 data", int'(d), 8'h6F);
    @(negedge clk);
    chk("R9 pulse one cycle", int'(c_rvalid | h_rvalid), 0);
    acc(0, 1'b1, sbuf(6, 30), 8'h5A, d, v, ov);
    chk("R9 no rvalid on write", int'(v | ov), 0);
  endtask

  task automatic t_unmapped;
    wr(0, 9'h0E0, 8'h77);
    wr(1, 9'h1E7, 3);
    wr(1, 9'h1EF, 1);
    wr(0, 9'h1FF, 8'hFF);
    rd_chk(0, 9'h0E0, 0, "R10 gap reads zero");
    rd_chk(0, 9'h1E7, 0, "R10 state gap reads zero");
    rd_chk(1, 9'h1FF, 0, "R10 top reads zero");
    rd_chk(0, sbuf(0, 0), 8'h11, "R10 buffer untouched");
    rd_chk(0, sst(0), 0, "R10 state untouched");
    chk("R10 no int0", int'(int0), 0);
    chk("R10 no int1", int'(int1), 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; h_valid = 0; h_we = 0; h_addr = '0; h_wdata = '0;
    c_valid = 0; c_we = 0; c_addr = '0; c_wdata = '0;
    clr_int0 = 0; clr_int1 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_buffers();
    t_reply();
    t_state_bits();
    t_int0();
    t_int1();
    t_set_wins();
    t_arb();
    t_read_lat();
    t_unmapped();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule